// File: doc/BRIEF.md
# Saturating Two-Digit Decimal Queue Sign

This block drives a two-digit "now serving" sign. A push button steps a decimal count upward from 00. A second push button clears the count. The count stops at 80 and stays there until it is cleared. The count is held as two BCD digits, ones and tens. It is shown on two common-cathode seven-segment digits that share one segment bus and are lit one at a time.

Both buttons are asynchronous to the system clock and pass through a two-flop synchronizer. The advance button also passes through a debounce filter. A press counts only after the synchronized level has held a new value for a parameterized time, 10 ms by default. Only the rising edge of the filtered level produces a one-cycle increment. Clear is a level: while it is held, both digits are forced to zero and any increment is discarded. Releasing clear has no effect of its own, so the count is still 00 afterwards.

The display scan divides the system clock, whose frequency is a parameter, so that the lit digit swaps every `CLK_HZ/SCAN_HZ` cycles, with `SCAN_HZ` defaulting to 2000.

Top module: `serve_sign_top`

## Requirements
- R1: While `rst_ni` is low, `dig_en_no` is 2'b11 and `seg_o` is 0. After reset the display shows 00, and the count is always a decimal value from 00 to 80.
- R2: Each accepted advance press raises the displayed count by exactly one.
- R3: An advance from a ones digit of 9 sets the ones digit to 0 and raises the tens digit by one in the same update (09 becomes 10, 19 becomes 20).
- R4: Once the tens digit is 8 (count 80), further advance presses are ignored and the display stays at 80.
- R5: While `clr_btn_i` is high, the count goes to 00. Releasing clear leaves the count at 00, not 01 or 10.
- R6: A press whose level chatters for less than the debounce time before settling high adds exactly one. A high pulse shorter than the debounce time adds nothing.
- R7: If an increment is accepted while clear is held, clear wins and the count stays at 00.
- R8: `seg_o` is active high, with segment a at bit 0 through segment g at bit 6. The codes for digits 0 to 9 are 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F. Any other code value shows blank (0x00).
- R9: `dig_en_no` is active low, with bit 0 enabling the ones digit and bit 1 the tens digit. The two bits are never low together. After reset, the lit digit swaps every `CLK_HZ/SCAN_HZ` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, frequency `CLK_HZ` |
| rst_ni | input | 1 | Asynchronous active-low reset |
| adv_btn_i | input | 1 | Raw advance button, active high, may bounce |
| clr_btn_i | input | 1 | Raw clear button, active high |
| seg_o | output | 7 | Active-high segment pattern, a at bit 0 |
| dig_en_no | output | 2 | Active-low digit enables: bit 0 ones, bit 1 tens |

## Verification
Clear and a debounced increment pulse can fall in the same cycle. When they do, the counter update must choose clear. The bench provokes this by holding clear high across a complete advance press, so the filtered rising edge is produced while clear is active. It then releases clear and expects the display to read 00. A second scenario releases clear with no press at all and must also read 00, which separates a clear that simply wins from a release that steps a digit.

// File: rtl/serve_pkg.sv
package serve_pkg;

  localparam int unsigned SEG_W  = 7;
  localparam int unsigned BCD_W  = 4;
  localparam int unsigned DIG_N  = 2;

  typedef logic [BCD_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0] seg_t;

  // segment a at bit 0 ... g at bit 6, active high
  function automatic seg_t bcd_to_seg(input bcd_t d);
    seg_t s;
    unique case (d)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int unsigned STABLE_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic level_o,
  output logic rise_o
);

  localparam int unsigned CW = (STABLE_CYC < 2) ? 1 : $clog2(STABLE_CYC);
  localparam logic [CW-1:0] CNT_LAST = CW'(STABLE_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      level_o <= 1'b0;
      rise_o  <= 1'b0;
    end else begin
      rise_o <= 1'b0;
      if (raw_i == level_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
        cnt_q   <= '0;
        level_o <= raw_i;
        rise_o  <= raw_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R6: one accepted edge yields a single-cycle pulse
  p_single_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

  // R6: filtered level only rises together with the pulse
  p_rise_marks_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(level_o) |-> rise_o);

endmodule

// File: rtl/bcd_sat_counter.sv
module bcd_sat_counter
  import serve_pkg::*;
#(
  parameter int unsigned LIMIT_TENS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output bcd_t ones_o,
  output bcd_t tens_o
);

  localparam bcd_t TENS_TOP = BCD_W'(LIMIT_TENS);
  localparam bcd_t ONES_TOP = BCD_W'(9);

  logic at_limit;
  logic ones_wrap;

  assign at_limit  = (tens_o == TENS_TOP);
  assign ones_wrap = (ones_o == ONES_TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_o <= '0;
      tens_o <= '0;
    end else if (clr_i) begin
      ones_o <= '0;
      tens_o <= '0;
    end else if (inc_i && !at_limit) begin
      if (ones_wrap) begin
        ones_o <= '0;
        tens_o <= tens_o + 1'b1;
      end else begin
        ones_o <= ones_o + 1'b1;
      end
    end
  end

  p_clear_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ones_o == '0 && tens_o == '0));

  p_clear_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && inc_i) |=> (ones_o == '0 && tens_o == '0));

  p_step_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && !at_limit && !ones_wrap) |=>
      (ones_o == $past(ones_o) + 1'b1 && $stable(tens_o)));

  p_carry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && !at_limit && ones_wrap) |=>
      (ones_o == '0 && tens_o == $past(tens_o) + 1'b1));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_limit && !clr_i) |=> ($stable(ones_o) && $stable(tens_o)));

  p_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ones_o <= ONES_TOP) && (tens_o <= TENS_TOP) && (!at_limit || ones_o == '0));

endmodule

// File: rtl/digit_scan.sv
module digit_scan
  import serve_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 50000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  bcd_t             ones_i,
  input  bcd_t             tens_i,
  output seg_t             seg_o,
  output logic [DIG_N-1:0] dig_en_no
);

  localparam int unsigned CW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
  localparam logic [CW-1:0] CNT_LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] div_q;
  logic          sel_q;   // 0: ones, 1: tens
  logic          tick;

  assign tick = (div_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      sel_q <= 1'b0;
    end else if (tick) begin
      div_q <= '0;
      sel_q <= ~sel_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_o     <= '0;
      dig_en_no <= '1;
    end else begin
      seg_o     <= bcd_to_seg(sel_q ? tens_i : ones_i);
      dig_en_no <= sel_q ? 2'b01 : 2'b10;
    end
  end

  p_no_overlap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dig_en_no != 2'b00);

  p_one_lit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $countones(dig_en_no) == 1);

  p_seg_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (seg_o != 7'h00));

endmodule

// File: rtl/serve_sign_top.sv
module serve_sign_top
  import serve_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned DEBOUNCE_US = 10_000,
  parameter int unsigned SCAN_HZ     = 2000,
  parameter int unsigned LIMIT_TENS  = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_btn_i,
  input  logic       clr_btn_i,
  output logic [6:0] seg_o,
  output logic [1:0] dig_en_no
);

  localparam longint DB_CALC    = (longint'(CLK_HZ) * longint'(DEBOUNCE_US)) / 64'd1_000_000;
  localparam int unsigned DB_CYC   = (DB_CALC < 1) ? 1 : int'(DB_CALC);
  localparam int unsigned HOLD_CYC = (CLK_HZ / SCAN_HZ < 1) ? 1 : CLK_HZ / SCAN_HZ;

  logic [1:0] btn_s;
  logic       adv_lvl;
  logic       inc;
  bcd_t       ones, tens;

  btn_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({clr_btn_i, adv_btn_i}),
    .sync_o  (btn_s)
  );

  btn_debounce #(.STABLE_CYC(DB_CYC)) u_db (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_i   (btn_s[0]),
    .level_o (adv_lvl),
    .rise_o  (inc)
  );

  bcd_sat_counter #(.LIMIT_TENS(LIMIT_TENS)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (btn_s[1]),
    .inc_i  (inc),
    .ones_o (ones),
    .tens_o (tens)
  );

  digit_scan #(.HOLD_CYC(HOLD_CYC)) u_scan (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ones_i    (ones),
    .tens_i    (tens),
    .seg_o     (seg_o),
    .dig_en_no (dig_en_no)
  );

  // R5: releasing clear never steps the count
  p_release_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(btn_s[1]) && !inc) |=> (ones == '0 && tens == '0));

  // R6: increments only come from a settled high level
  p_inc_needs_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc |-> adv_lvl);

endmodule

// File: tb/serve_sign_tb.sv
module serve_sign_top_tb_top;

  localparam int unsigned CLK_HZ = 200_000;
  localparam int unsigned DB_US  = 1000;   // 200 cycles
  localparam int unsigned SCAN   = 2000;   // swap every 100 cycles
  localparam int DB_CYC   = 200;
  localparam int HOLD_CYC = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       adv = 1'b0;
  logic       clr = 1'b0;
  logic [6:0] seg;
  logic [1:0] dig_en_n;

  int checks = 0;
  int fails  = 0;
  int model  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  serve_sign_top #(
    .CLK_HZ(CLK_HZ), .DEBOUNCE_US(DB_US), .SCAN_HZ(SCAN), .LIMIT_TENS(8)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .adv_btn_i(adv), .clr_btn_i(clr),
    .seg_o(seg), .dig_en_no(dig_en_n)
  );

  function automatic logic [6:0] code_of(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic read_disp(output logic [6:0] s_one, output logic [6:0] s_ten);
    @(negedge clk);
    while (dig_en_n !== 2'b10) begin
      check(dig_en_n !== 2'b00, "R9", "both digits lit", dig_en_n, 1);
      @(negedge clk);
    end
    s_one = seg;
    while (dig_en_n !== 2'b01) begin
      check(dig_en_n !== 2'b00, "R9", "both digits lit", dig_en_n, 1);
      @(negedge clk);
    end
    s_ten = seg;
  endtask

  task automatic expect_count(input int exp, input string req);
    logic [6:0] so, st;
    read_disp(so, st);
    check(so === code_of(exp % 10), req, "ones segments", so, code_of(exp % 10));
    check(st === code_of(exp / 10), req, "tens segments", st, code_of(exp / 10));
  endtask

  task automatic press();
    adv = 1'b1; repeat (DB_CYC + 40) @(posedge clk);
    adv = 1'b0; repeat (DB_CYC + 40) @(posedge clk);
    if (model < 80) model++;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check(dig_en_n === 2'b11, "R1", "enables in reset", dig_en_n, 2'b11);
    check(seg === 7'h00, "R1", "segments in reset", seg, 0);
    rst_n = 1'b1;
    model = 0;
    expect_count(0, "R1");
  endtask

  task automatic t_scan();
    int n = 0;
    logic [1:0] prev;
    @(negedge clk);
    while (dig_en_n !== 2'b10) @(negedge clk);
    while (dig_en_n === 2'b10) @(negedge clk);
    prev = dig_en_n;
    while (dig_en_n === prev) begin n++; @(negedge clk); end
    check(n == HOLD_CYC, "R9", "scan dwell cycles", n, HOLD_CYC);
    check(prev === 2'b01, "R9", "alternate digit", prev, 2'b01);
  endtask

  task automatic t_steps();
    for (int i = 0; i < 3; i++) begin
      press();
      expect_count(model, "R2");
    end
  endtask

  task automatic t_bounce();
    for (int i = 0; i < 6; i++) begin
      adv = 1'b1; repeat (15) @(posedge clk);
      adv = 1'b0; repeat (10) @(posedge clk);
    end
    adv = 1'b1; repeat (DB_CYC + 40) @(posedge clk);
    for (int i = 0; i < 6; i++) begin
      adv = 1'b0; repeat (15) @(posedge clk);
      adv = 1'b1; repeat (10) @(posedge clk);
    end
    adv = 1'b0; repeat (DB_CYC + 40) @(posedge clk);
    model++;
    expect_count(model, "R6");
    // short glitch below debounce time
    adv = 1'b1; repeat (DB_CYC / 2) @(posedge clk);
    adv = 1'b0; repeat (DB_CYC + 40) @(posedge clk);
    expect_count(model, "R6");
  endtask

  task automatic t_carry();
    while (model < 9) begin
      press();
      expect_count(model, "R8");
    end
    press();
    expect_count(model, "R3");
    while (model < 19) press();
    press();
    expect_count(model, "R3");
  endtask

  task automatic t_saturate();
    while (model < 80) press();
    expect_count(80, "R4");
    for (int i = 0; i < 4; i++) press();
    expect_count(80, "R4");
  endtask

  task automatic t_clear();
    clr = 1'b1; repeat (30) @(posedge clk);
    expect_count(0, "R5");
    clr = 1'b0; repeat (DB_CYC + 40) @(posedge clk);
    model = 0;
    expect_count(0, "R5");
  endtask

  task automatic t_clear_wins();
    press(); press();
    expect_count(model, "R2");
    clr = 1'b1; repeat (10) @(posedge clk);
    adv = 1'b1; repeat (DB_CYC + 40) @(posedge clk);
    adv = 1'b0; repeat (DB_CYC + 40) @(posedge clk);
    expect_count(0, "R7");
    clr = 1'b0; repeat (DB_CYC + 40) @(posedge clk);
    model = 0;
    expect_count(0, "R7");
    press();
    expect_count(1, "R2");
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_scan();
    t_steps();
    t_bounce();
    t_carry();
    t_saturate();
    t_clear();
    t_clear_wins();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule